// File: doc/BRIEF.md
# Backlight PWM Dimming Selector

This block produces the lamp-enable signal for a backlight controller. A select input picks the source of the dimming waveform. With select low, an externally supplied logic-level PWM is synchronised and passed through to the lamp enable. While it passes through, its period is also measured and judged against an allowed frequency window. With select high, which is the default strap level, the block makes its own PWM. It compares a free-running sawtooth counter with a digital duty word, and that word plays the part of a DC dimming level. A backlight-on input gates the result, so the lamp enable is forced low whenever the backlight is switched off.

All widths and rates are parameters. The sawtooth period is the system clock rate divided by the target PWM rate (180 Hz by default). The allowed external window is 120 Hz to 300 Hz. The internal duty never drops below 30 %: a smaller request is raised to that floor. The select and backlight-on inputs are synchronous to the clock. Only the external PWM line is synchronised inside the block.

Top module: `bl_dim_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, lamp_en is 0 and freq_fault is 0.
- R2: When bl_on is 0 on a clock edge, lamp_en is 0 after that edge, whatever the source.
- R3: With src_int = 0 and bl_on = 1, lamp_en equals the value ext_pwm had three clock edges earlier (two synchroniser stages plus the output register).
- R4: With src_int = 1, the sawtooth runs through PER = CLK_HZ/PWM_HZ counts starting from 0 after reset. In each period lamp_en is high for ceil(d*PER/DMAX) cycles, where DMAX = 2^DUTY_W-1 and d is the effective duty code (200-cycle period and 101 high cycles for code 128 in the bench setting).
- R5: An internal duty code of all ones gives lamp_en continuously high (100 %).
- R6: An internal duty code below MIN_CODE = ceil(DMAX*MIN_PCT/100) is raised to MIN_CODE (77 for 8 bits and 30 %). Codes 0 and 76 therefore behave exactly like 77, and code 78 gives one more high cycle per period.
- R7: An external PWM held high continuously gives lamp_en continuously high and leaves freq_fault at 0 (a DC level counts as full duty).
- R8: The external period is the number of cycles between successive synchronised rising edges. A rising edge whose period is below CLK_HZ/F_MAX_HZ or above CLK_HZ/F_MIN_HZ sets the fault; an in-range period clears it. The first rising edge after reset is not judged.
- R9: If more than CLK_HZ/F_MIN_HZ cycles pass without a rising edge, the fault is set while the line is low and cleared while it is high.
- R10: freq_fault reads 0 whenever src_int = 1. The measured fault state is kept and shows again when src_int returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_int | input | 1 | Source select: 1 = internal sawtooth compare, 0 = external PWM |
| bl_on | input | 1 | Backlight on; 0 forces the lamp enable off |
| ext_pwm | input | 1 | External logic-level PWM, asynchronous |
| duty | input | DUTY_W | Internal duty code, full scale = 100 % |
| lamp_en | output | 1 | Registered lamp drive enable |
| freq_fault | output | 1 | External PWM period outside the allowed window |

## Verification
The hardest state to reach is a fault change at the exact edge of the period window. The bench drives trains of external pulses whose rising edges are 119, 120, 300 and 301 cycles apart, with the bench clock rate scaled down so that those windows are short. A long low hold and then a long high hold reach the timeout branch in both polarities. The flag is then hidden and revealed by toggling the select. The duty floor is probed with codes on both sides of the clamp, counting high cycles over exactly one sawtooth period.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;
   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_INT = 1'b1
   } src_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/bl_saw_pwm.sv
module bl_saw_pwm #(
   parameter int PER      = 200,
   parameter int DUTY_W   = 8,
   parameter int MIN_CODE = 77,
   localparam int RW      = $clog2(PER)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] duty,
   output logic [RW-1:0]     ramp,
   output logic              pwm
);
   localparam int DMAX  = (1 << DUTY_W) - 1;
   localparam int PRODW = RW + DUTY_W + 1;

   logic [DUTY_W-1:0] d_eff;
   logic [PRODW-1:0]  lhs;
   logic [PRODW-1:0]  rhs;

   generate
      if (MIN_CODE > 0) begin : g_clamp
         always_comb d_eff = (duty < DUTY_W'(MIN_CODE)) ? DUTY_W'(MIN_CODE) : duty;
      end else begin : g_noclamp
         always_comb d_eff = duty;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ramp <= '0;
      else if (ramp == RW'(PER-1)) ramp <= '0;
      else                         ramp <= ramp + 1'b1;
   end

   // ramp/PER < d/DMAX without a divider
   assign lhs = PRODW'(ramp)  * PRODW'(DMAX);
   assign rhs = PRODW'(d_eff) * PRODW'(PER);
   assign pwm = (lhs < rhs);
endmodule

// File: rtl/bl_ext_mon.sv
module bl_ext_mon #(
   parameter int SYNC_N  = 2,
   parameter int MIN_P   = 120,
   parameter int MAX_P   = 300,
   localparam int CW     = $clog2(MAX_P + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_raw,
   output logic ext_clean,
   output logic fault
);
   logic [SYNC_N-1:0] stg;
   logic              prev;
   logic              seen;
   logic              rise;
   logic [CW-1:0]     since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[SYNC_N-2:0], ext_raw};
   end

   assign ext_clean = stg[SYNC_N-1];
   assign rise      = ext_clean & ~prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         seen  <= 1'b0;
         fault <= 1'b0;
         since <= '0;
      end else begin
         prev <= ext_clean;
         if (rise) begin
            if (seen) fault <= (since < CW'(MIN_P)) || (since > CW'(MAX_P));
            seen  <= 1'b1;
            since <= CW'(1);
         end else if (since > CW'(MAX_P)) begin
            fault <= ~ext_clean;
         end else begin
            since <= since + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bl_dim_sel.sv
module bl_dim_sel
   import bl_dim_pkg::*;
#(
   parameter int CLK_HZ   = 200_000_000,
   parameter int PWM_HZ   = 180,
   parameter int F_MIN_HZ = 120,
   parameter int F_MAX_HZ = 300,
   parameter int DUTY_W   = 8,
   parameter int MIN_PCT  = 30,
   parameter int SYNC_N   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_int,
   input  logic              bl_on,
   input  logic              ext_pwm,
   input  logic [DUTY_W-1:0] duty,
   output logic              lamp_en,
   output logic              freq_fault
);
   localparam int PER      = CLK_HZ / PWM_HZ;
   localparam int MIN_P    = CLK_HZ / F_MAX_HZ;
   localparam int MAX_P    = CLK_HZ / F_MIN_HZ;
   localparam int DMAX     = (1 << DUTY_W) - 1;
   localparam int MIN_CODE = ceil_div(DMAX * MIN_PCT, 100);
   localparam int RW       = $clog2(PER);

   generate
      if (PWM_HZ < F_MIN_HZ || PWM_HZ > F_MAX_HZ) begin : g_bad_rate
         $error("bl_dim_sel: PWM_HZ outside the allowed window");
      end
      if (MIN_PCT < 0 || MIN_PCT > 100) begin : g_bad_pct
         $error("bl_dim_sel: MIN_PCT must be 0..100");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("bl_dim_sel: SYNC_N must be at least 2");
      end
      if (PER < 2 || DUTY_W < 2 || DUTY_W > 16) begin : g_bad_size
         $error("bl_dim_sel: period or duty width out of range");
      end
   endgenerate

   logic [RW-1:0] ramp;
   logic          int_pwm;
   logic          ext_clean;
   logic          fault_q;
   logic          src_lvl;

   bl_saw_pwm #(.PER(PER), .DUTY_W(DUTY_W), .MIN_CODE(MIN_CODE)) u_saw (
      .clk   (clk),
      .rst_n (rst_n),
      .duty  (duty),
      .ramp  (ramp),
      .pwm   (int_pwm)
   );

   bl_ext_mon #(.SYNC_N(SYNC_N), .MIN_P(MIN_P), .MAX_P(MAX_P)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_raw   (ext_pwm),
      .ext_clean (ext_clean),
      .fault     (fault_q)
   );

   always_comb begin
      unique case (src_e'(src_int))
         SRC_INT: src_lvl = int_pwm;
         default: src_lvl = ext_clean;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lamp_en <= 1'b0;
      else        lamp_en <= bl_on & src_lvl;
   end

   assign freq_fault = fault_q & (src_e'(src_int) == SRC_EXT);
endmodule

// File: rtl/bl_dim_sel_chk.sv
module bl_dim_sel_chk #(
   parameter int PER      = 200,
   parameter int DUTY_W   = 8,
   parameter int MIN_CODE = 77,
   localparam int RW      = $clog2(PER)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              src_int,
   input logic              bl_on,
   input logic [DUTY_W-1:0] duty,
   input logic [RW-1:0]     ramp,
   input logic              ext_clean,
   input logic              lamp_en
);
   localparam int DMAX   = (1 << DUTY_W) - 1;
   localparam int MIN_HI = (MIN_CODE * PER + DMAX - 1) / DMAX;

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_OFF_WHEN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(bl_on) |-> !lamp_en); // R2

   AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(bl_on && !src_int) |-> lamp_en == $past(ext_clean)); // R3

   AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ramp) < PER); // R4

   AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(bl_on && src_int && (&duty)) |-> lamp_en); // R5

   AST_DUTY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(bl_on && src_int && (int'(ramp) < MIN_HI)) |-> lamp_en); // R6
endmodule

bind bl_dim_sel bl_dim_sel_chk #(.PER(PER), .DUTY_W(DUTY_W), .MIN_CODE(MIN_CODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_int   (src_int),
   .bl_on     (bl_on),
   .duty      (duty),
   .ramp      (ramp),
   .ext_clean (ext_clean),
   .lamp_en   (lamp_en)
);

// File: tb/tb_bl_dim_sel.sv
module tb_bl_dim_sel;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CLK_HZ = 36000;
   localparam int PER    = CLK_HZ / 180;   // 200
   localparam int MINP   = CLK_HZ / 300;   // 120
   localparam int MAXP   = CLK_HZ / 120;   // 300
   localparam int DMAX   = 255;
   localparam int MINC   = 77;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic src_int = 1'b1;
   logic bl_on = 1'b0;
   logic ext_pwm = 1'b0;
   logic [7:0] duty = 8'd0;
   logic lamp_en, freq_fault;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bl_dim_sel #(.CLK_HZ(CLK_HZ)) dut (
      .clk(clk), .rst_n(rst_n), .src_int(src_int), .bl_on(bl_on),
      .ext_pwm(ext_pwm), .duty(duty), .lamp_en(lamp_en), .freq_fault(freq_fault)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int m_ramp = 0;
   bit m_lamp = 0;
   bit m_fault = 0;
   bit m_seen = 0;
   bit m_prev = 0;
   int m_since = 0;
   bit m_sync[$] = '{0, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ramp = 0; m_lamp = 0; m_fault = 0; m_seen = 0; m_prev = 0; m_since = 0;
         m_sync = '{0, 0};
      end else begin
         int deff;
         bit clean, hi_int, rise;
         deff   = (int'(duty) < MINC) ? MINC : int'(duty);
         clean  = m_sync[1];
         hi_int = (m_ramp * DMAX) < (deff * PER);
         m_lamp = bl_on && (src_int ? hi_int : clean);
         rise   = clean && !m_prev;
         if (rise) begin
            if (m_seen) m_fault = (m_since < MINP) || (m_since > MAXP);
            m_seen = 1; m_since = 1;
         end else if (m_since > MAXP) m_fault = !clean;
         else m_since++;
         m_prev = clean;
         void'(m_sync.pop_back());
         m_sync.push_front(ext_pwm);
         m_ramp = (m_ramp == PER - 1) ? 0 : m_ramp + 1;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(lamp_en == m_lamp, !bl_on ? "R2" : (src_int ? "R4" : "R3"), lamp_en, m_lamp);
         chk(freq_fault == (m_fault && !src_int), src_int ? "R10" : "R8", freq_fault,
             m_fault && !src_int);
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic count_high(output int c);
      c = 0;
      repeat (PER) begin
         @(negedge clk);
         if (lamp_en) c++;
      end
      #1;
   endtask

   task automatic duty_probe(input int code, input int exp, input string req);
      int c;
      duty = 8'(code);
      step(PER + 10);
      count_high(c);
      chk(c == exp, req, c, exp);
   endtask

   task automatic ext_train(input int p, input int h, input int n);
      for (int k = 0; k < n; k++) begin
         for (int j = 0; j < p; j++) begin
            ext_pwm = (j < h);
            step();
         end
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      step(3);
      chk(lamp_en == 0, "R1", lamp_en, 0);
      chk(freq_fault == 0, "R1", freq_fault, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(lamp_en == 0, "R1", lamp_en, 0);
      chk(freq_fault == 0, "R1", freq_fault, 0);
      #1;

      // internal sawtooth source
      bl_on = 1'b1;
      duty_probe(128, 101, "R4");
      duty_probe(255, 200, "R5");
      duty_probe(0, 61, "R6");
      duty_probe(76, 61, "R6");
      duty_probe(77, 61, "R6");
      duty_probe(78, 62, "R6");
      duty_probe(200, 157, "R4");

      // backlight off
      bl_on = 1'b0;
      step(50);
      chk(lamp_en == 0, "R2", lamp_en, 0);
      bl_on = 1'b1;

      // external source, period window
      src_int = 1'b0;
      ext_train(200, 60, 4);
      chk(freq_fault == 0, "R8", freq_fault, 0);
      ext_train(119, 40, 4);
      chk(freq_fault == 1, "R8", freq_fault, 1);
      ext_train(120, 40, 4);
      chk(freq_fault == 0, "R8", freq_fault, 0);
      ext_train(301, 100, 3);
      chk(freq_fault == 1, "R8", freq_fault, 1);
      ext_train(300, 100, 4);
      chk(freq_fault == 0, "R8", freq_fault, 0);

      // stuck low, then DC high
      ext_pwm = 1'b0;
      step(400);
      chk(freq_fault == 1, "R9", freq_fault, 1);
      ext_pwm = 1'b1;
      step(400);
      chk(freq_fault == 0, "R7", freq_fault, 0);
      chk(lamp_en == 1, "R7", lamp_en, 1);

      // masking by select
      ext_pwm = 1'b0;
      step(400);
      chk(freq_fault == 1, "R9", freq_fault, 1);
      src_int = 1'b1;
      step(5);
      chk(freq_fault == 0, "R10", freq_fault, 0);
      src_int = 1'b0;
      step(2);
      chk(freq_fault == 1, "R10", freq_fault, 1);

      step(5);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule